// File: doc/BRIEF.md
# IDLE-Cycle Rule Monitor for a Pipelined Bus Subordinate

This block watches one subordinate port of a single-master pipelined system bus and checks that transfer-free cycles stay inert. It takes the transfer-type code, the select, the bus-level ready, the subordinate's own ready and response, and an access strobe that the subordinate exports whenever it really touches its storage. When a selected address phase carries the IDLE code and the bus is ready, the monitor remembers that the following data phase belongs to a non-transfer. It then checks that phase for a real access, a wait state or an ERROR response. On the master side it checks that the second cycle of a two-cycle ERROR response carries the IDLE code, which cancels the transfer already in flight.

Each rule has its own registered violation pulse and its own saturating counter. A sticky summary flag shows that any rule has been broken since the last clear. The block drives nothing on the bus. It sits beside a subordinate in simulation or in silicon debug logic.

The address-phase side is handled by a tracker state machine with three states. TRK_OPEN means no IDLE data phase is pending. TRK_IDLE_DP is the first cycle of an IDLE data phase. TRK_IDLE_HELD is a later cycle of an IDLE data phase that has been extended by a low bus ready. From any state, a cycle with bus ready high goes to TRK_IDLE_DP if the address phase is a selected IDLE, and to TRK_OPEN otherwise. A cycle with bus ready low goes from TRK_IDLE_DP or TRK_IDLE_HELD to TRK_IDLE_HELD, and keeps TRK_OPEN in TRK_OPEN.

The master side is handled by a second machine with two states. EC_WATCH moves to EC_SECOND on a cycle with response high and bus ready low. EC_SECOND always returns to EC_WATCH after one cycle.

Top module: `idle_cycle_monitor`

## Requirements
- R1: The IDLE code is htrans = 2'b00; NONSEQ is 2'b10 and SEQ is 2'b11. The IDLE data-phase rules apply only to the data phase of an address phase that has htrans = 2'b00, hsel = 1 and hready = 1. Data phases of NONSEQ or SEQ transfers, and of IDLE phases with hsel = 0, raise no IDLE violation.
- R2: Phantom access (violation bit 0): acc_strobe high in any cycle of an IDLE data phase, including extended cycles. Each such cycle is flagged once.
- R3: IDLE stall (violation bit 1): hreadyout low with hresp low in the first cycle of an IDLE data phase. It is flagged once per data phase. The data phase lasts while hready stays low.
- R4: ERROR to IDLE (violation bit 2): hresp high in the first cycle of an IDLE data phase.
- R5: Missing cancel (violation bit 3): a cycle with hresp high and hready low, followed by a cycle whose htrans is not 2'b00. The flag belongs to that second cycle.
- R6: Each violation bit has its own CNT_W-bit counter (default 8). The counter adds one for every flagged cycle and holds at its all-ones value.
- R7: err_sticky is set by any violation. It is cleared by clr_sticky only in a cycle with no violation, and a violation in the same cycle wins. clr_sticky leaves the counters unchanged.
- R8: Reset (active-low, asynchronous) clears all outputs. In the first cycle after reset no data phase is assumed pending, so no violation is recorded for that cycle.
- R9: viol is a registered pulse. It is visible right after the clock edge that ends the offending cycle, and counters and err_sticky update on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_sticky | input | 1 | Synchronous clear of err_sticky |
| htrans | input | 2 | Transfer type from the master |
| hsel | input | 1 | Select of the watched subordinate |
| hready | input | 1 | Bus-level ready (previous transfer done) |
| hreadyout | input | 1 | Ready driven by the watched subordinate |
| hresp | input | 1 | Response from the subordinate, 1 = ERROR |
| acc_strobe | input | 1 | Subordinate's real-access strobe |
| viol | output | 4 | Per-rule violation pulse: [0] phantom, [1] stall, [2] error, [3] no cancel |
| err_sticky | output | 1 | Sticky any-violation flag |
| cnt_phantom | output | CNT_W | Phantom access count |
| cnt_stall | output | CNT_W | IDLE stall count |
| cnt_err_resp | output | CNT_W | ERROR-to-IDLE count |
| cnt_no_cancel | output | CNT_W | Missing cancel count |

## Verification
The bench aligns address and data phases on purpose so that a monitor checking the wrong cycle would show up. A strobe placed in the data phase of a NONSEQ, SEQ or unselected IDLE must stay silent, and a strobe placed in the data phase of a selected IDLE must be flagged. A design that checks the address cycle itself would flag these cases the wrong way round. An IDLE data phase stretched by a low ready is used to show two things: a stall is counted once and not per cycle, and a strobe in an extended cycle is still a phantom access. The ERROR response is driven both into an IDLE data phase and after a NONSEQ, with the master either cancelling or not. A design that dropped the two-cycle tracking would miss or misplace the cancel flag. The bench also covers a clear that arrives together with a violation, counter saturation after several hundred back-to-back phantom cycles, and a first cycle after reset filled with bad values.

// File: rtl/idle_mon_pkg.sv
package idle_mon_pkg;

    localparam logic [1:0] HT_IDLE = 2'b00;

    localparam int NUM_RULES    = 4;
    localparam int RULE_PHANTOM = 0;
    localparam int RULE_STALL   = 1;
    localparam int RULE_ERRRSP  = 2;
    localparam int RULE_CANCEL  = 3;

    typedef enum logic [1:0] {
        TRK_OPEN      = 2'd0,
        TRK_IDLE_DP   = 2'd1,
        TRK_IDLE_HELD = 2'd2
    } trk_state_t;

    typedef enum logic {
        EC_WATCH  = 1'b0,
        EC_SECOND = 1'b1
    } ec_state_t;

endpackage

// File: rtl/idle_dp_tracker.sv
module idle_dp_tracker
    import idle_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] htrans,
    input  logic       hsel,
    input  logic       hready,
    output logic       dp_first,
    output logic       dp_held
);

    trk_state_t state_q, state_d;
    logic       idle_addr;

    assign idle_addr = hsel && hready && (htrans == HT_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_OPEN: begin
                if (idle_addr) state_d = TRK_IDLE_DP;
            end
            TRK_IDLE_DP, TRK_IDLE_HELD: begin
                if (!hready)        state_d = TRK_IDLE_HELD;
                else if (idle_addr) state_d = TRK_IDLE_DP;
                else                state_d = TRK_OPEN;
            end
            default: state_d = TRK_OPEN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRK_OPEN;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        dp_first = 1'b0;
        dp_held  = 1'b0;
        unique case (state_q)
            TRK_OPEN:      ;
            TRK_IDLE_DP:   dp_first = 1'b1;
            TRK_IDLE_HELD: dp_held  = 1'b1;
            default:       ;
        endcase
    end

    // R3: an extended IDLE data phase only follows a cycle with bus ready low
    assert_held_after_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_IDLE_HELD) |-> $past(!hready));

    // R1: a selected IDLE address phase always opens an IDLE data phase
    assert_idle_opens_dp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && hready && htrans == HT_IDLE) |=> dp_first);

endmodule

// File: rtl/err_cancel_watch.sv
module err_cancel_watch
    import idle_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hready,
    input  logic hresp,
    output logic at_second
);

    ec_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EC_WATCH:  if (hresp && !hready) state_d = EC_SECOND;
            EC_SECOND: state_d = EC_WATCH;
            default:   state_d = EC_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EC_WATCH;
        else        state_q <= state_d;
    end

    always_comb begin
        at_second = 1'b0;
        unique case (state_q)
            EC_WATCH:  at_second = 1'b0;
            EC_SECOND: at_second = 1'b1;
            default:   at_second = 1'b0;
        endcase
    end

    // R5: the second error cycle is entered only from a first error cycle
    assert_second_after_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        at_second |-> $past(hresp && !hready));

endmodule

// File: rtl/sat_count.sv
module sat_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // R6: a saturated counter stays saturated
    assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX) |=> (cnt == CNT_MAX));

    // R6: the counter never moves backwards
    assert_no_decrease_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt >= $past(cnt));

endmodule

// File: rtl/idle_cycle_monitor.sv
module idle_cycle_monitor
    import idle_mon_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_sticky,
    input  logic [1:0]       htrans,
    input  logic             hsel,
    input  logic             hready,
    input  logic             hreadyout,
    input  logic             hresp,
    input  logic             acc_strobe,
    output logic [3:0]       viol,
    output logic             err_sticky,
    output logic [CNT_W-1:0] cnt_phantom,
    output logic [CNT_W-1:0] cnt_stall,
    output logic [CNT_W-1:0] cnt_err_resp,
    output logic [CNT_W-1:0] cnt_no_cancel
);

    logic                 dp_first, dp_held, at_second;
    logic [NUM_RULES-1:0] det;
    logic [NUM_RULES-1:0] viol_q;
    logic [CNT_W-1:0]     cnt_arr [NUM_RULES];

    idle_dp_tracker u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .htrans   (htrans),
        .hsel     (hsel),
        .hready   (hready),
        .dp_first (dp_first),
        .dp_held  (dp_held)
    );

    err_cancel_watch u_ec (
        .clk       (clk),
        .rst_n     (rst_n),
        .hready    (hready),
        .hresp     (hresp),
        .at_second (at_second)
    );

    // rule detection for the current cycle
    always_comb begin
        det                = '0;
        det[RULE_PHANTOM]  = (dp_first || dp_held) && acc_strobe;
        det[RULE_STALL]    = dp_first && !hreadyout && !hresp;
        det[RULE_ERRRSP]   = dp_first && hresp;
        det[RULE_CANCEL]   = at_second && (htrans != HT_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol_q     <= '0;
            err_sticky <= 1'b0;
        end else begin
            viol_q <= det;
            if (|det)           err_sticky <= 1'b1;
            else if (clr_sticky) err_sticky <= 1'b0;
        end
    end

    for (genvar g = 0; g < NUM_RULES; g++) begin : g_cnt
        sat_count #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (det[g]),
            .cnt   (cnt_arr[g])
        );

        // R6: a flagged rule always has a non-zero count
        assert_count_follows_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
            viol_q[g] |-> (cnt_arr[g] != '0));
    end

    assign viol          = viol_q;
    assign cnt_phantom   = cnt_arr[RULE_PHANTOM];
    assign cnt_stall     = cnt_arr[RULE_STALL];
    assign cnt_err_resp  = cnt_arr[RULE_ERRRSP];
    assign cnt_no_cancel = cnt_arr[RULE_CANCEL];

    // R7: any flagged rule leaves the sticky flag set
    assert_sticky_on_viol_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|viol_q) |-> err_sticky);

    // R7: the sticky flag only falls after a clear request
    assert_sticky_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_sticky) |-> $past(clr_sticky));

    // R8: nothing is flagged for the first cycle after reset
    assert_quiet_after_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> (viol_q == '0));

    // R2: a phantom flag needs a strobe in the previous cycle
    assert_phantom_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        viol_q[RULE_PHANTOM] |-> $past(acc_strobe));

    // R4: an error-to-IDLE flag needs an ERROR response in the previous cycle
    assert_errrsp_needs_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        viol_q[RULE_ERRRSP] |-> $past(hresp));

endmodule

// File: tb/test_idle_cycle_monitor.sv
module test_idle_cycle_monitor;

    localparam int CNT_W = 8;
    localparam int SAT   = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr_sticky = 1'b0;
    logic [1:0]       htrans = 2'b00;
    logic             hsel = 1'b0;
    logic             hready = 1'b1;
    logic             hreadyout = 1'b1;
    logic             hresp = 1'b0;
    logic             acc_strobe = 1'b0;
    logic [3:0]       viol;
    logic             err_sticky;
    logic [CNT_W-1:0] cnt_phantom, cnt_stall, cnt_err_resp, cnt_no_cancel;

    int n_checks = 0;
    int n_fails  = 0;

    logic [4:0] q_exp [$];
    string      q_tag [$];
    logic [4:0] mon_item;
    string      mon_tag;
    int         exp_cnt [4] = '{0, 0, 0, 0};
    logic       exp_sticky = 1'b0;

    always #4 clk = ~clk;

    idle_cycle_monitor #(.CNT_W(CNT_W)) i_idle_cycle_monitor (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr_sticky    (clr_sticky),
        .htrans        (htrans),
        .hsel          (hsel),
        .hready        (hready),
        .hreadyout     (hreadyout),
        .hresp         (hresp),
        .acc_strobe    (acc_strobe),
        .viol          (viol),
        .err_sticky    (err_sticky),
        .cnt_phantom   (cnt_phantom),
        .cnt_stall     (cnt_stall),
        .cnt_err_resp  (cnt_err_resp),
        .cnt_no_cancel (cnt_no_cancel)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // driver: one bus cycle plus its expected violation vector
    task automatic cyc(input logic [1:0] tr, input logic hs, input logic hr,
                       input logic hro, input logic rsp, input logic stb,
                       input logic clr, input logic [3:0] ev, input string tag);
        @(negedge clk);
        htrans = tr; hsel = hs; hready = hr; hreadyout = hro;
        hresp = rsp; acc_strobe = stb; clr_sticky = clr;
        q_exp.push_back({clr, ev});
        q_tag.push_back(tag);
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #1;
        if (q_exp.size() > 0) begin
            mon_item = q_exp.pop_front();
            mon_tag  = q_tag.pop_front();
            for (int i = 0; i < 4; i++)
                if (mon_item[i] && exp_cnt[i] < SAT) exp_cnt[i]++;
            if (|mon_item[3:0])  exp_sticky = 1'b1;
            else if (mon_item[4]) exp_sticky = 1'b0;
            chk({mon_tag, " viol"}, int'(viol), int'(mon_item[3:0]));
            chk("R6 counters", int'({cnt_phantom, cnt_stall, cnt_err_resp, cnt_no_cancel}),
                (exp_cnt[0] << 24) | (exp_cnt[1] << 16) | (exp_cnt[2] << 8) | exp_cnt[3]);
            chk("R7 sticky", int'(err_sticky), int'(exp_sticky));
        end
    end

    task automatic check_reset_state();
        chk("R8 reset viol", int'(viol), 0);
        chk("R8 reset sticky", int'(err_sticky), 0);
        chk("R8 reset counters", int'({cnt_phantom, cnt_stall, cnt_err_resp, cnt_no_cancel}), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_reset_state();
        // first cycle after reset filled with bad values (R8)
        @(negedge clk);
        htrans = 2'b00; hsel = 1'b1; hready = 1'b0; hreadyout = 1'b0;
        hresp = 1'b1; acc_strobe = 1'b1;
        rst_n = 1'b1;
        q_exp.push_back(5'b0); q_tag.push_back("R8 first cycle");
        cyc(2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, "R5 cancel honoured");
        // clean IDLE then real transfers (R1)
        cyc(2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, "R1 idle addr");
        cyc(2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, "R1 clean idle dp");
        cyc(2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0000, "R1 nonseq strobe");
        cyc(2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0000, "R1 seq strobe");
        cyc(2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0000, "R1 unselected idle");
        // phantom (R2)
        cyc(2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0001, "R2 phantom");
        // stall once per phase (R3)
        cyc(2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, "R3 idle addr");
        cyc(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0010, "R3 stall");
        cyc(2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, "R3 stall once");
        // ERROR to IDLE then honoured cancel (R4, R5)
        cyc(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0100, "R4 error to idle");
        cyc(2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, "R5 cancel ok");
        // ERROR to NONSEQ without cancel (R5)
        cyc(2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, "R5 nonseq addr");
        cyc(2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000, "R5 first err");
        cyc(2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b1000, "R5 no cancel");
        // stall with strobe, phantom in extended cycle (R2, R3, R9)
        cyc(2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, "R9 idle addr");
        cyc(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0011, "R2 R3 stall strobe");
        cyc(2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0001, "R2 held phantom");
        // sticky clear (R7)
        cyc(2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0000, "R7 clear");
        cyc(2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, "R7 idle addr");
        cyc(2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'b0001, "R7 clear loses");
        cyc(2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0000, "R7 clear again");
        // saturation (R6)
        cyc(2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, "R6 idle addr");
        for (int k = 0; k < 300; k++)
            cyc(2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0001, "R6 saturate");
        cyc(2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, "R6 quiet");
        @(posedge clk); #2;
        chk("R6 saturated", int'(cnt_phantom), SAT);
        // reset again (R8)
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_reset_state();
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule